// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns the two phase signals of an incremental rotary or linear encoder, plus the once-per-revolution index mark, into a 16-bit position count. Each of the three inputs is first brought into the clock domain. It then passes through a digital glitch filter whose sample rate is programmable. The filtered phases are compared with their values from the previous cycle. Every valid Gray-code step moves the count by one, in the direction given by which phase leads. A step where both phases flip at once is illegal; it is flagged and does not count.

The count runs between zero and a programmable maximum and wraps at either end. Wrapping past the top raises a one-cycle overflow pulse. Wrapping below zero raises a one-cycle underflow pulse. A rising edge of the filtered index can clear the count. A separate mode turns the counter into a free-running timer that advances once per prescaled clock.

Top module: `qdec_core`

## Requirements
- R1: After reset, pos is 0, dir is 0, and ovf_irq, unf_irq and seq_err are all 0.
- R2: A filtered input takes a new level only when three consecutive samples agree. Samples are taken once every flt_div+1 clocks. A pulse covering fewer than three samples has no effect on pos.
- R3: In x4 mode (mode = 2'b10), every single-phase edge moves pos by one. With the AB state sequence 00, 10, 11, 01, 00 (A leading), pos counts up; in the reverse order it counts down.
- R4: In x2 mode (mode = 2'b01), only edges of phase A move pos. Edges of phase B leave pos unchanged.
- R5: dir is 1 after an up step and 0 after a down step. It holds its value otherwise.
- R6: In x2 or x4 mode, a change of both filtered phases in the same cycle leaves pos unchanged and raises seq_err for one cycle.
- R7: Counting up from a value at or above max_cnt loads 0 and raises ovf_irq for one cycle.
- R8: Counting down from 0 loads max_cnt and raises unf_irq for one cycle.
- R9: In x2 or x4 mode with idx_clr_en = 1, a rising edge of the filtered index loads 0. This takes priority over a step in the same cycle: no step, no pulse, and dir is unchanged. With idx_clr_en = 0 the index has no effect.
- R10: In timer mode (mode = 2'b11), pos increments once every tmr_div+1 clocks, wraps from max_cnt to 0, and raises ovf_irq on each wrap.
- R11: In off mode (mode = 2'b00), pos holds its value whatever the phase inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 off, 01 x2, 10 x4, 11 timer |
| idx_clr_en | input | 1 | Let the index rising edge clear the count |
| flt_div | input | 8 | Filter sample period minus one, in clocks |
| tmr_div | input | 8 | Timer prescale period minus one, in clocks |
| max_cnt | input | 16 | Upper wrap value of the count |
| pha | input | 1 | Encoder phase A (asynchronous) |
| phb | input | 1 | Encoder phase B (asynchronous) |
| idx | input | 1 | Encoder index mark (asynchronous) |
| pos | output | 16 | Position or timer count |
| dir | output | 1 | Direction of the last counted step, 1 = up |
| ovf_irq | output | 1 | One-cycle pulse on upward wrap |
| unf_irq | output | 1 | One-cycle pulse on downward wrap |
| seq_err | output | 1 | One-cycle pulse on an illegal double-phase change |

## Verification
Two events can land in the same cycle: an index clear and a phase step. A double-phase error can also coincide with a clear. The bench provokes the first case by driving the index rising edge and a phase-A edge onto the pins together. Both then pass through identical synchronizers and filters, so their filtered edges arrive in the same clock. The result is judged by the count reading 0, dir keeping its previous value, and no overflow or underflow pulse being seen. Random walks with a small max_cnt supply the wrap cases, which are checked against a bench model of the count and the pulse totals.

// File: rtl/qdec_core.sv
module qdec_core #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          idx_clr_en,
  input  logic [DW-1:0] flt_div,
  input  logic [DW-1:0] tmr_div,
  input  logic [CW-1:0] max_cnt,
  input  logic          pha,
  input  logic          phb,
  input  logic          idx,
  output logic [CW-1:0] pos,
  output logic          dir,
  output logic          ovf_irq,
  output logic          unf_irq,
  output logic          seq_err
);
  localparam logic [1:0] M_OFF = 2'b00, M_X2 = 2'b01, M_X4 = 2'b10, M_TMR = 2'b11;
  localparam int NIN = 3;

  logic [NIN-1:0] sy1, sy2, filt, filt_q;
  logic [DW-1:0]  fcnt, tcnt;
  logic           ftick, ttick;

  assign ftick = (fcnt == flt_div);
  assign ttick = (tcnt == tmr_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; filt_q <= '0;
      fcnt <= '0; tcnt <= '0;
    end else begin
      sy1 <= {idx, phb, pha};
      sy2 <= sy1;
      filt_q <= filt;
      fcnt <= ftick ? '0 : fcnt + 1'b1;
      tcnt <= ttick ? '0 : tcnt + 1'b1;
    end
  end

  for (genvar i = 0; i < NIN; i++) begin : g_flt
    logic [1:0] hist;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist <= '0;
        filt[i] <= 1'b0;
      end else if (ftick) begin
        hist <= {hist[0], sy2[i]};
        if (hist == 2'b11 && sy2[i]) filt[i] <= 1'b1;
        else if (hist == 2'b00 && !sy2[i]) filt[i] <= 1'b0;
      end
    end
  end

  logic a_chg, b_chg, up, quad, step, err, clr, inc, dec, at_top;

  assign a_chg  = filt[0] ^ filt_q[0];
  assign b_chg  = filt[1] ^ filt_q[1];
  assign up     = filt[0] ^ filt_q[1];
  assign quad   = (mode == M_X2) || (mode == M_X4);
  assign err    = quad && a_chg && b_chg;
  assign step   = ((mode == M_X4) && (a_chg ^ b_chg)) ||
                  ((mode == M_X2) && a_chg && !b_chg);
  assign clr    = quad && idx_clr_en && filt[2] && !filt_q[2];
  assign inc    = (mode == M_TMR) ? ttick : (step && up);
  assign dec    = step && !up;
  assign at_top = (pos >= max_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; dir <= 1'b0;
      ovf_irq <= 1'b0; unf_irq <= 1'b0; seq_err <= 1'b0;
    end else begin
      ovf_irq <= 1'b0;
      unf_irq <= 1'b0;
      seq_err <= err;
      if (clr) begin
        pos <= '0;
      end else begin
        if (step) dir <= up;
        if (inc) begin
          if (at_top) begin pos <= '0; ovf_irq <= 1'b1; end
          else pos <= pos + 1'b1;
        end else if (dec) begin
          if (pos == '0) begin pos <= max_cnt; unf_irq <= 1'b1; end
          else pos <= pos - 1'b1;
        end
      end
    end
  end

  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_irq && unf_irq)); // R7
  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> pos == '0); // R7
  AST_UNF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    unf_irq |-> pos == $past(max_cnt)); // R8
  AST_ERR_NOSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> !ovf_irq && !unf_irq); // R6
  AST_OVF_DIR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq && $past(mode) == M_X4) |-> dir); // R5
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_OFF && $past(rst_n)) |-> $stable(pos)); // R11
endmodule

// File: tb/sim_qdec_core.sv
`timescale 1ns/1ps
module sim_qdec_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic idx_clr_en = 1'b0;
  logic [7:0] flt_div = 8'd0, tmr_div = 8'd0;
  logic [15:0] max_cnt = 16'hFFFF;
  logic pha = 1'b0, phb = 1'b0, idx = 1'b0;
  logic [15:0] pos;
  logic dir, ovf_irq, unf_irq, seq_err;

  qdec_core u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .idx_clr_en(idx_clr_en),
    .flt_div(flt_div), .tmr_div(tmr_div), .max_cnt(max_cnt), .pha(pha), .phb(phb),
    .idx(idx), .pos(pos), .dir(dir), .ovf_irq(ovf_irq), .unf_irq(unf_irq), .seq_err(seq_err));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int n_ovf = 0, n_unf = 0, n_err = 0;
  int e_ovf = 0, e_unf = 0, e_err = 0;
  logic [15:0] e_pos = 16'd0;
  logic e_dir = 1'b0;
  int ms = 0;
  bit done = 1'b0;

  always @(negedge clk) if (rst_n) begin
    n_ovf += int'(ovf_irq); n_unf += int'(unf_irq); n_err += int'(seq_err);
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [1:0] ab_of(input int s);
    case (s & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic settle();
    repeat ((int'(flt_div) + 1) * 5 + 6) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; pha = 1'b0; phb = 1'b0; idx = 1'b0;
    repeat (4) @(negedge clk); rst_n = 1'b1;
    settle();
    e_pos = 0; e_dir = 0; ms = 0;
    n_ovf = 0; n_unf = 0; n_err = 0; e_ovf = 0; e_unf = 0; e_err = 0;
  endtask

  task automatic model_count(input bit upv);
    e_dir = upv;
    if (upv) begin
      if (e_pos >= max_cnt) begin e_pos = 0; e_ovf++; end else e_pos = e_pos + 1;
    end else begin
      if (e_pos == 0) begin e_pos = max_cnt; e_unf++; end else e_pos = e_pos - 1;
    end
  endtask

  task automatic move(input int ns, input bit with_idx);
    logic [1:0] o, n;
    bit ac, bc, quad, stp, clr;
    o = ab_of(ms); n = ab_of(ns);
    pha = n[1]; phb = n[0];
    if (with_idx) idx = 1'b1;
    settle();
    ac = o[1] != n[1]; bc = o[0] != n[0];
    quad = (mode == 2'b01) || (mode == 2'b10);
    clr = quad && with_idx && idx_clr_en;
    stp = (mode == 2'b10 && (ac ^ bc)) || (mode == 2'b01 && ac && !bc);
    if (quad && ac && bc) e_err++;
    if (clr) e_pos = 0;
    else if (quad && stp) model_count(n[1] ^ o[0]);
    ms = ns & 3;
    if (with_idx) begin idx = 1'b0; settle(); end
  endtask

  task automatic chk_state(input string req);
    chk({req, " pos"}, int'(pos), int'(e_pos));
    chk({req, " dir"}, int'(dir), int'(e_dir));
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int p;
    void'($urandom(32'h51D3));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 pos", int'(pos), 0); chk("R1 dir", int'(dir), 0);
    chk("R1 ovf", int'(ovf_irq), 0); chk("R1 unf", int'(unf_irq), 0);
    chk("R1 err", int'(seq_err), 0);
    do_reset();

    // R3 x4 up then down
    mode = 2'b10; max_cnt = 16'd1000;
    for (int k = 1; k <= 4; k++) move(ms + 1, 0);
    chk_state("R3 x4 up");
    move(ms + 3, 0); chk_state("R5 down dir");
    move(ms + 3, 0); chk_state("R3 x4 down");

    // R4 x2 counts A edges only
    do_reset(); mode = 2'b01; max_cnt = 16'd1000;
    for (int k = 1; k <= 8; k++) move(ms + 1, 0);
    chk_state("R4 x2 up");
    chk("R4 x2 count", int'(pos), 4);

    // R8 underflow reload, R7 overflow back
    do_reset(); mode = 2'b10; max_cnt = 16'd7;
    move(ms + 3, 0); chk_state("R8 unf");
    chk("R8 unf pulses", n_unf, 1);
    move(ms + 1, 0); chk_state("R7 ovf");
    chk("R7 ovf pulses", n_ovf, 1);

    // R6 double change
    move(ms + 2, 0); chk_state("R6 pos hold");
    chk("R6 err pulses", n_err, e_err);

    // R9 index clear, coincident step, disabled
    do_reset(); mode = 2'b10; max_cnt = 16'd1000; idx_clr_en = 1'b1;
    for (int k = 1; k <= 3; k++) move(ms + 1, 0);
    idx = 1'b1; settle(); e_pos = 0; idx = 1'b0; settle();
    chk_state("R9 clear");
    move(ms + 1, 0); move(ms + 1, 0);
    move(ms + 3, 1); chk_state("R9 coincident");
    chk("R9 no pulse", n_ovf + n_unf, 0);
    idx_clr_en = 1'b0; move(ms + 1, 0);
    idx = 1'b1; settle(); idx = 1'b0; settle();
    chk_state("R9 disabled");

    // R11 off mode holds
    mode = 2'b00;
    for (int k = 1; k <= 5; k++) move(ms + 1, 0);
    chk_state("R11 hold");

    // R2 glitch rejection with slow sampling
    mode = 2'b10; flt_div = 8'd3;
    @(negedge clk); pha = ~pha; repeat (6) @(negedge clk); pha = ~pha;
    settle(); chk_state("R2 glitch");
    move(ms + 1, 0); chk_state("R2 accept");
    flt_div = 8'd0;

    // random walk in x4 with small wrap (R3 R5 R6 R7 R8)
    do_reset(); mode = 2'b10; max_cnt = 16'(4 + $urandom % 12);
    for (int k = 0; k < 150; k++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) move(ms + 2, 0);
      else if (r < 8) move(ms + 1, 0);
      else move(ms + 3, 0);
      chk_state("R3 walk");
    end
    chk("R7 walk ovf", n_ovf, e_ovf);
    chk("R8 walk unf", n_unf, e_unf);
    chk("R6 walk err", n_err, e_err);

    // R10 timer mode
    do_reset(); max_cnt = 16'd9; tmr_div = 8'd2; mode = 2'b11;
    @(negedge clk); p = int'(pos);
    n_ovf = 0;
    repeat (39) @(negedge clk);
    chk("R10 timer pos", int'(pos), (p + 13) % 10);
    chk("R10 timer ovf", n_ovf, (p + 13) / 10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule